// File: doc/BRIEF.md
# Clock Tree Frequency Evaluator

This block works out, in hertz, the rates of the derived clocks of a clock tree from the current values of its control fields. The fields are inputs. They cover the system PLL multiplier choice, two fractional dividers on the system PLL, the source selects and the integer post-dividers. A one-cycle `start` pulse copies every field into a private snapshot. The block then walks the tree from the crystal reference down to the peripheral timer clock. Each division step is done on one shared serial divider, one quotient bit per cycle.

When the walk ends, `done` pulses for one cycle. In the same cycle the bus, IPG and peripheral timer rates update together as 32-bit values, along with a flag that marks a zero fractional field on the fractional divider that was selected. `start` and `done` are plain control pins. Nothing can apply back-pressure: a `start` that arrives while `busy` is high is dropped, and results are not queued. A fixed output reports the reference divided by eight.

Top module: `clk_tree_eval`

## Requirements
- R1: After reset, `bus_hz`, `ipg_hz`, `per_hz`, `pfd_err`, `busy` and `done` are all 0.
- R2: The system PLL rate is 24,000,000 × 22 when `pll_sys_div22` is 1 and 24,000,000 × 20 when it is 0. With `pre_sel`=0, `periph_sel`=0 and both bus post-dividers at 0, `bus_hz` equals that rate.
- R3: A fractional output is the system PLL rate × 18 divided by its fraction field, using integer truncation. `pre_sel` encoding: 0 selects the system PLL, 1 selects the `pfd2_frac` output, 2 selects the `pfd0_frac` output, and 3 selects the `pfd2_frac` output halved (truncated).
- R4: `clk2_sel` encoding: 0 selects the USB PLL (24,000,000 × 20), 1 selects the 24 MHz reference, 2 selects the bypass input (0 Hz), and 3 is reserved (0 Hz). The result is divided by 1 + `clk2_podf`. `periph_sel`=1 routes this path to the peripheral clock, and `periph_sel`=0 routes the `pre_sel` path.
- R5: `bus_hz` = peripheral clock / (1 + `ahb_podf`) and `ipg_hz` = `bus_hz` / (1 + `ipg_podf`). Each stage truncates.
- R6: `per_hz` = source / (1 + `per_podf`), where the source is `ipg_hz` when `per_sel`=0 and the 24 MHz reference when `per_sel`=1.
- R7: `ref_div_hz` is always 3,000,000.
- R8: When `pre_sel` picks a fractional output whose fraction field is 0, no division by that field takes place, the pre-peripheral rate is 0 and `pfd_err` is 1. A zero field on the fractional output that is not selected leaves `pfd_err` at 0.
- R9: A `start` while `busy` is high is ignored. Fields are sampled only on an accepted `start`, and later field changes do not affect that evaluation.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. `done` lasts one cycle. The outputs and `pfd_err` change only in a `done` cycle.
- R11: Intermediate rates are held in 40 bits. A peripheral rate above 2^32 − 1 appears in the outputs truncated to its low 32 bits (for example, 528 MHz × 18 / 1 reports 914,065,408).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an evaluation (pulse) |
| pll_sys_div22 | input | 1 | System PLL multiplier: 1 selects ×22, 0 selects ×20 |
| pre_sel | input | 2 | Pre-peripheral source select |
| pfd0_frac | input | FRAC_W | Fraction field of fractional output 0 |
| pfd2_frac | input | FRAC_W | Fraction field of fractional output 2 |
| clk2_sel | input | 2 | Alternate peripheral source select |
| clk2_podf | input | CLK2_PODF_W | Alternate path post-divider minus one |
| periph_sel | input | 1 | Peripheral clock path select |
| ahb_podf | input | AHB_PODF_W | Bus post-divider minus one |
| ipg_podf | input | IPG_PODF_W | IPG post-divider minus one |
| per_sel | input | 1 | Timer clock source select |
| per_podf | input | PER_PODF_W | Timer post-divider minus one |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_hz | output | OUT_W | Bus clock rate in Hz |
| ipg_hz | output | OUT_W | IPG clock rate in Hz |
| per_hz | output | OUT_W | Peripheral timer clock rate in Hz |
| ref_div_hz | output | OUT_W | Reference divided by eight, in Hz |
| pfd_err | output | 1 | Selected fraction field was zero |

## Verification
The bench builds the block with its default parameters. These are a 24 MHz reference, 40-bit intermediates, 6-bit fraction fields and a 6-bit timer post-divider. With these values a fraction of 1 pushes the peripheral rate past 32 bits, so the truncation case can be exercised. They also give the largest timer divisor of 64 and a 41-cycle division per step. Field changes and a second `start` issued in the middle of an evaluation fall inside that window, which lets the bench show that the snapshot is isolated from later field changes.

// File: rtl/clk_tree_eval_pkg.sv
package clk_tree_eval_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CLK2,
    ST_BUS,
    ST_IPG,
    ST_PER
  } eval_state_t;

  function automatic int wmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/clk_tree_eval_divider.sv
module clk_tree_eval_divider #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] shf_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  // restoring step: bring down next dividend bit, subtract when it fits
  assign trial = {rem_q, shf_q[NUM_W-1]};
  assign fits  = (trial >= {1'b0, den_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      shf_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        rem_q <= '0;
        shf_q <= num;
        den_q <= den;
        cnt_q <= CNT_W'(NUM_W - 1);
        busy  <= 1'b1;
      end else if (busy) begin
        if (fits) begin
          rem_q <= DEN_W'(trial - {1'b0, den_q});
          shf_q <= {shf_q[NUM_W-2:0], 1'b1};
        end else begin
          rem_q <= trial[DEN_W-1:0];
          shf_q <= {shf_q[NUM_W-2:0], 1'b0};
        end
        if (cnt_q == '0) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign quo = shf_q;

  AST_NONZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (den != '0)); // R8

  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R9

  AST_FIN_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ($past(busy) && !busy)); // R10

endmodule

// File: rtl/clk_tree_eval_operands.sv
module clk_tree_eval_operands
  import clk_tree_eval_pkg::*;
#(
  parameter int REF_HZ      = 24_000_000,
  parameter int PROD_W      = 40,
  parameter int DEN_W       = 7,
  parameter int FRAC_W      = 6,
  parameter int CLK2_PODF_W = 3,
  parameter int AHB_PODF_W  = 3,
  parameter int IPG_PODF_W  = 2,
  parameter int PER_PODF_W  = 6
) (
  input  eval_state_t             state,
  input  logic                    div22,
  input  logic [1:0]              pre_sel,
  input  logic [FRAC_W-1:0]       pfd0_frac,
  input  logic [FRAC_W-1:0]       pfd2_frac,
  input  logic [1:0]              clk2_sel,
  input  logic [CLK2_PODF_W-1:0]  clk2_podf,
  input  logic                    periph_sel,
  input  logic [AHB_PODF_W-1:0]   ahb_podf,
  input  logic [IPG_PODF_W-1:0]   ipg_podf,
  input  logic                    per_sel,
  input  logic [PER_PODF_W-1:0]   per_podf,
  input  logic [PROD_W-1:0]       pre_hz,
  input  logic [PROD_W-1:0]       clk2_hz,
  input  logic [PROD_W-1:0]       bus_hz,
  input  logic [PROD_W-1:0]       ipg_hz,
  output logic [PROD_W-1:0]       num,
  output logic [DEN_W-1:0]        den,
  output logic                    pfd_zero
);
  localparam logic [PROD_W-1:0] REF_W  = PROD_W'(REF_HZ);
  localparam logic [PROD_W-1:0] USB_HZ = REF_W * PROD_W'(20);
  localparam logic [DEN_W-1:0]  ONE    = DEN_W'(1);

  logic [PROD_W-1:0] sys_hz;
  logic [PROD_W-1:0] pfd_num;
  logic [FRAC_W-1:0] frac;
  logic              use_pfd;
  logic [PROD_W-1:0] clk2_src;
  logic [PROD_W-1:0] periph_hz;

  assign sys_hz   = REF_W * PROD_W'(div22 ? 22 : 20);
  assign pfd_num  = sys_hz * PROD_W'(18);
  assign frac     = (pre_sel == 2'd2) ? pfd0_frac : pfd2_frac;
  assign use_pfd  = (pre_sel != 2'd0);
  assign pfd_zero = use_pfd && (frac == '0);

  always_comb begin
    case (clk2_sel)
      2'd0:    clk2_src = USB_HZ;
      2'd1:    clk2_src = REF_W;
      default: clk2_src = '0;   // bypass input and reserved code
    endcase
  end

  assign periph_hz = periph_sel ? clk2_hz : pre_hz;

  always_comb begin
    num = '0;
    den = ONE;
    case (state)
      ST_PRE: begin
        if (!use_pfd) begin
          num = sys_hz;
        end else if (!pfd_zero) begin
          num = pfd_num;
          den = DEN_W'(frac);
        end
      end
      ST_CLK2: begin
        num = clk2_src;
        den = DEN_W'(clk2_podf) + ONE;
      end
      ST_BUS: begin
        num = periph_hz;
        den = DEN_W'(ahb_podf) + ONE;
      end
      ST_IPG: begin
        num = bus_hz;
        den = DEN_W'(ipg_podf) + ONE;
      end
      ST_PER: begin
        num = per_sel ? REF_W : ipg_hz;
        den = DEN_W'(per_podf) + ONE;
      end
      default: begin
        num = '0;
        den = ONE;
      end
    endcase
  end

endmodule

// File: rtl/clk_tree_eval.sv
module clk_tree_eval
  import clk_tree_eval_pkg::*;
#(
  parameter int REF_HZ      = 24_000_000,
  parameter int PROD_W      = 40,
  parameter int OUT_W       = 32,
  parameter int FRAC_W      = 6,
  parameter int CLK2_PODF_W = 3,
  parameter int AHB_PODF_W  = 3,
  parameter int IPG_PODF_W  = 2,
  parameter int PER_PODF_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    pll_sys_div22,
  input  logic [1:0]              pre_sel,
  input  logic [FRAC_W-1:0]       pfd0_frac,
  input  logic [FRAC_W-1:0]       pfd2_frac,
  input  logic [1:0]              clk2_sel,
  input  logic [CLK2_PODF_W-1:0]  clk2_podf,
  input  logic                    periph_sel,
  input  logic [AHB_PODF_W-1:0]   ahb_podf,
  input  logic [IPG_PODF_W-1:0]   ipg_podf,
  input  logic                    per_sel,
  input  logic [PER_PODF_W-1:0]   per_podf,
  output logic                    busy,
  output logic                    done,
  output logic [OUT_W-1:0]        bus_hz,
  output logic [OUT_W-1:0]        ipg_hz,
  output logic [OUT_W-1:0]        per_hz,
  output logic [OUT_W-1:0]        ref_div_hz,
  output logic                    pfd_err
);
  localparam int DEN_W = wmax(wmax(FRAC_W, CLK2_PODF_W),
                              wmax(wmax(AHB_PODF_W, IPG_PODF_W), PER_PODF_W)) + 1;

  eval_state_t state;
  logic        issue;

  // snapshot of the fields taken at an accepted start
  logic                   s_div22;
  logic [1:0]             s_pre;
  logic [FRAC_W-1:0]      s_pfd0;
  logic [FRAC_W-1:0]      s_pfd2;
  logic [1:0]             s_c2sel;
  logic [CLK2_PODF_W-1:0] s_c2podf;
  logic                   s_psel;
  logic [AHB_PODF_W-1:0]  s_ahb;
  logic [IPG_PODF_W-1:0]  s_ipg;
  logic                   s_persel;
  logic [PER_PODF_W-1:0]  s_perpodf;

  logic [PROD_W-1:0] pre_r, c2_r, bus_r, ipg_r;
  logic              err_r;

  logic [PROD_W-1:0] op_num;
  logic [DEN_W-1:0]  op_den;
  logic              op_pfd_zero;
  logic              div_busy, div_fin;
  logic [PROD_W-1:0] div_quo;

  clk_tree_eval_operands #(
    .REF_HZ(REF_HZ), .PROD_W(PROD_W), .DEN_W(DEN_W), .FRAC_W(FRAC_W),
    .CLK2_PODF_W(CLK2_PODF_W), .AHB_PODF_W(AHB_PODF_W),
    .IPG_PODF_W(IPG_PODF_W), .PER_PODF_W(PER_PODF_W)
  ) i_ops (
    .state(state), .div22(s_div22), .pre_sel(s_pre),
    .pfd0_frac(s_pfd0), .pfd2_frac(s_pfd2),
    .clk2_sel(s_c2sel), .clk2_podf(s_c2podf), .periph_sel(s_psel),
    .ahb_podf(s_ahb), .ipg_podf(s_ipg), .per_sel(s_persel), .per_podf(s_perpodf),
    .pre_hz(pre_r), .clk2_hz(c2_r), .bus_hz(bus_r), .ipg_hz(ipg_r),
    .num(op_num), .den(op_den), .pfd_zero(op_pfd_zero)
  );

  clk_tree_eval_divider #(.NUM_W(PROD_W), .DEN_W(DEN_W)) i_div (
    .clk(clk), .rst_n(rst_n), .go(issue), .num(op_num), .den(op_den),
    .busy(div_busy), .fin(div_fin), .quo(div_quo)
  );

  assign busy       = (state != ST_IDLE);
  assign ref_div_hz = OUT_W'(REF_HZ / 8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      issue     <= 1'b0;
      s_div22   <= 1'b0;
      s_pre     <= '0;
      s_pfd0    <= '0;
      s_pfd2    <= '0;
      s_c2sel   <= '0;
      s_c2podf  <= '0;
      s_psel    <= 1'b0;
      s_ahb     <= '0;
      s_ipg     <= '0;
      s_persel  <= 1'b0;
      s_perpodf <= '0;
      pre_r     <= '0;
      c2_r      <= '0;
      bus_r     <= '0;
      ipg_r     <= '0;
      err_r     <= 1'b0;
      done      <= 1'b0;
      bus_hz    <= '0;
      ipg_hz    <= '0;
      per_hz    <= '0;
      pfd_err   <= 1'b0;
    end else begin
      done  <= 1'b0;
      issue <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            s_div22   <= pll_sys_div22;
            s_pre     <= pre_sel;
            s_pfd0    <= pfd0_frac;
            s_pfd2    <= pfd2_frac;
            s_c2sel   <= clk2_sel;
            s_c2podf  <= clk2_podf;
            s_psel    <= periph_sel;
            s_ahb     <= ahb_podf;
            s_ipg     <= ipg_podf;
            s_persel  <= per_sel;
            s_perpodf <= per_podf;
            state     <= ST_PRE;
            issue     <= 1'b1;
          end
        end
        ST_PRE: if (div_fin) begin
          pre_r <= (s_pre == 2'd3) ? (div_quo >> 1) : div_quo;
          err_r <= op_pfd_zero;
          state <= ST_CLK2;
          issue <= 1'b1;
        end
        ST_CLK2: if (div_fin) begin
          c2_r  <= div_quo;
          state <= ST_BUS;
          issue <= 1'b1;
        end
        ST_BUS: if (div_fin) begin
          bus_r <= div_quo;
          state <= ST_IPG;
          issue <= 1'b1;
        end
        ST_IPG: if (div_fin) begin
          ipg_r <= div_quo;
          state <= ST_PER;
          issue <= 1'b1;
        end
        ST_PER: if (div_fin) begin
          bus_hz  <= bus_r[OUT_W-1:0];
          ipg_hz  <= ipg_r[OUT_W-1:0];
          per_hz  <= div_quo[OUT_W-1:0];
          pfd_err <= err_r;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R10

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(bus_hz) && $stable(ipg_hz) && $stable(per_hz) && $stable(pfd_err))); // R10

  AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(s_pre) && $stable(s_pfd0) && $stable(s_pfd2)
                               && $stable(s_c2sel) && $stable(s_perpodf))); // R9

  AST_ERR_NEEDS_PFD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pfd_err) |-> (s_pre != 2'd0)); // R8

  AST_DIV_WITHIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> busy); // R10

endmodule

// File: tb/test_clk_tree_eval.sv
`timescale 1ns/1ps
module test_clk_tree_eval;

  typedef struct packed {
    logic [3:0] req;
    logic       d22;
    logic [1:0] pre;
    logic [5:0] p0;
    logic [5:0] p2;
    logic [1:0] c2s;
    logic [2:0] c2p;
    logic       ps;
    logic [2:0] ahb;
    logic [1:0] ipg;
    logic       pers;
    logic [5:0] perp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  1'b1, 2'd0, 6'd0,  6'd0,  2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0, 6'd0},  // R2 x22
    '{4'd5,  1'b0, 2'd0, 6'd0,  6'd0,  2'd0, 3'd0, 1'b0, 3'd3, 2'd1, 1'b0, 6'd0},  // R2 R5 x20
    '{4'd3,  1'b1, 2'd1, 6'd0,  6'd24, 2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0, 6'd1},  // R3 pfd2
    '{4'd3,  1'b1, 2'd2, 6'd27, 6'd0,  2'd0, 3'd0, 1'b0, 3'd1, 2'd1, 1'b0, 6'd0},  // R3 pfd0
    '{4'd3,  1'b1, 2'd3, 6'd0,  6'd24, 2'd0, 3'd0, 1'b0, 3'd0, 2'd3, 1'b0, 6'd2},  // R3 pfd2 halved
    '{4'd4,  1'b1, 2'd0, 6'd0,  6'd0,  2'd0, 3'd2, 1'b1, 3'd0, 2'd0, 1'b0, 6'd0},  // R4 usb pll
    '{4'd6,  1'b0, 2'd0, 6'd0,  6'd0,  2'd1, 3'd0, 1'b1, 3'd0, 2'd0, 1'b1, 6'd5},  // R4 R6 reference
    '{4'd4,  1'b1, 2'd0, 6'd0,  6'd0,  2'd2, 3'd1, 1'b1, 3'd0, 2'd0, 1'b0, 6'd0},  // R4 bypass
    '{4'd4,  1'b1, 2'd0, 6'd0,  6'd0,  2'd3, 3'd0, 1'b1, 3'd0, 2'd0, 1'b1, 6'd0},  // R4 reserved
    '{4'd6,  1'b1, 2'd0, 6'd0,  6'd0,  2'd0, 3'd0, 1'b0, 3'd7, 2'd3, 1'b0, 6'd63}, // R6 max divisor
    '{4'd8,  1'b1, 2'd1, 6'd18, 6'd0,  2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b1, 6'd0},  // R8 zero selected
    '{4'd8,  1'b0, 2'd1, 6'd0,  6'd16, 2'd0, 3'd0, 1'b0, 3'd1, 2'd0, 1'b0, 6'd0},  // R8 zero unselected
    '{4'd11, 1'b1, 2'd2, 6'd1,  6'd0,  2'd0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0, 6'd0}   // R11 wrap
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pll_sys_div22 = 1'b0;
  logic [1:0] pre_sel = '0;
  logic [5:0] pfd0_frac = '0;
  logic [5:0] pfd2_frac = '0;
  logic [1:0] clk2_sel = '0;
  logic [2:0] clk2_podf = '0;
  logic periph_sel = 1'b0;
  logic [2:0] ahb_podf = '0;
  logic [1:0] ipg_podf = '0;
  logic per_sel = 1'b0;
  logic [5:0] per_podf = '0;
  logic busy, done, pfd_err;
  logic [31:0] bus_hz, ipg_hz, per_hz, ref_div_hz;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  clk_tree_eval i_clk_tree_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_sys_div22(pll_sys_div22),
    .pre_sel(pre_sel), .pfd0_frac(pfd0_frac), .pfd2_frac(pfd2_frac),
    .clk2_sel(clk2_sel), .clk2_podf(clk2_podf), .periph_sel(periph_sel),
    .ahb_podf(ahb_podf), .ipg_podf(ipg_podf), .per_sel(per_sel), .per_podf(per_podf),
    .busy(busy), .done(done), .bus_hz(bus_hz), .ipg_hz(ipg_hz), .per_hz(per_hz),
    .ref_div_hz(ref_div_hz), .pfd_err(pfd_err)
  );

  task automatic chk(input bit ok, input int r, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // reference model written from the requirement text
  task automatic model(input vec_t v, output longint eb, output longint ei,
                       output longint ep, output bit ee);
    longint sys, pre, pf, c2, per_src, periph;
    sys = 64'd24000000 * (v.d22 ? 22 : 20);
    ee = 1'b0;
    case (v.pre)
      2'd0: pre = sys;
      2'd2: begin
        if (v.p0 == 0) begin pre = 0; ee = 1'b1; end
        else pre = sys * 18 / v.p0;
      end
      default: begin
        if (v.p2 == 0) begin pre = 0; ee = 1'b1; end
        else begin
          pf = sys * 18 / v.p2;
          pre = (v.pre == 2'd3) ? pf / 2 : pf;
        end
      end
    endcase
    case (v.c2s)
      2'd0: c2 = 64'd480000000;
      2'd1: c2 = 64'd24000000;
      default: c2 = 0;
    endcase
    c2 = c2 / (1 + v.c2p);
    periph = v.ps ? c2 : pre;
    eb = periph / (1 + v.ahb);
    ei = eb / (1 + v.ipg);
    per_src = v.pers ? 64'd24000000 : ei;
    ep = per_src / (1 + v.perp);
    eb = eb & 64'hFFFF_FFFF;
    ei = ei & 64'hFFFF_FFFF;
    ep = ep & 64'hFFFF_FFFF;
  endtask

  task automatic apply(input vec_t v);
    pll_sys_div22 = v.d22; pre_sel = v.pre; pfd0_frac = v.p0; pfd2_frac = v.p2;
    clk2_sel = v.c2s; clk2_podf = v.c2p; periph_sel = v.ps; ahb_podf = v.ahb;
    ipg_podf = v.ipg; per_sel = v.pers; per_podf = v.perp;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int r, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    chk(seen, r, "done seen", longint'(seen), 1);
  endtask

  task automatic check_vec(input vec_t v);
    longint eb, ei, ep;
    bit ee;
    model(v, eb, ei, ep, ee);
    chk(bus_hz == eb[31:0], v.req, "bus_hz", bus_hz, eb);
    chk(ipg_hz == ei[31:0], v.req, "ipg_hz", ipg_hz, ei);
    chk(per_hz == ep[31:0], v.req, "per_hz", per_hz, ep);
    chk(pfd_err == ee, v.req, "pfd_err", pfd_err, ee);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    vec_t a, b;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_hz == 0 && ipg_hz == 0 && per_hz == 0, 1, "outputs after reset", bus_hz, 0);
    chk(!busy && !done && !pfd_err, 1, "flags after reset", {busy, done, pfd_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 fixed divided reference
    chk(ref_div_hz == 32'd3000000, 7, "ref_div_hz", ref_div_hz, 3000000);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      pulse_start();
      wait_done(TBL[i].req, seen);
      check_vec(TBL[i]);
    end

    // R10: done is a single cycle, then outputs hold while next run is busy
    a = TBL[0];
    b = TBL[5];
    apply(a);
    pulse_start();
    wait_done(10, seen);
    @(negedge clk);
    chk(!done, 10, "done width", done, 0);
    apply(b);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(busy, 10, "busy mid-run", busy, 1);
    chk(bus_hz == 32'd528000000, 10, "bus_hz held while busy", bus_hz, 528000000);

    // R9: mid-run field changes and a second start are ignored
    apply(a);
    pulse_start();
    wait_done(9, seen);
    check_vec(b);
    begin
      bit extra;
      extra = 1'b0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (done || busy) extra = 1'b1;
      end
      chk(!extra, 9, "no run from ignored start", extra, 0);
    end

    // R9 R10: accepted start right after done begins a fresh evaluation
    apply(TBL[12]);
    pulse_start();
    chk(busy, 10, "busy after start", busy, 1);
    wait_done(11, seen);
    check_vec(TBL[12]);

    // R1: reset mid-run clears outputs
    apply(TBL[3]);
    pulse_start();
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bus_hz == 0 && !busy && !pfd_err, 1, "reset mid-run", bus_hz, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule